// File: doc/BRIEF.md
# Frame Processing Sequencer

This controller decides when one frame (or field) of pixel processing starts and when it is over. A host-owned enable bit (`go_en`) and an external `start_in` level must both be high before the sequencer arms. Once armed, it waits for the trigger that belongs to the current direction. In compression the trigger is a rising edge on the vertical sync input. In expansion the trigger is a rising edge on the data sync from the codec side. The sequencer then holds `frame_busy` high until the datapath reports the end of the frame with a one-cycle `frame_done` pulse.

In single-frame operation the sequencer asks the host register to drop its enable bit through a one-cycle `go_clear` pulse and then returns to idle. In sequential operation the enable bit stays set, and a new frame starts on every trigger for as long as `start_in` stays high.

The block also conditions the hard reset pin. A low pulse that is too short is ignored. A qualified reset drives the internal reset `core_rst_n`, which stays asserted for a short while after the pin is released. That same internal reset clears the sequencer.

Top module: `frame_seq`

## Requirements
- R1: `core_rst_n` goes low at the clock edge after the edge that samples `hard_rst_n` low for the 8th consecutive time. While `core_rst_n` is low, `frame_busy` and `go_clear` are 0.
- R2: After a qualified reset, `core_rst_n` stays low until the third clock edge after the edge that first samples `hard_rst_n` high, and goes high at that edge.
- R3: A low pulse on `hard_rst_n` that lasts fewer than 8 samples has no effect: `core_rst_n` stays high and a frame in progress keeps `frame_busy` high.
- R4: No frame starts unless `go_en` and `start_in` are both high on the cycle before the trigger edge (the arming cycle) and also on the trigger cycle itself.
- R5: With `compress`=1, a frame starts on a rising edge of `vsync_in`. `frame_busy` is 1 from the edge after the first high sample. A rising edge of `dsync_in` starts nothing.
- R6: With `compress`=0, a frame starts on a rising edge of `dsync_in` with the same timing as R5. A rising edge of `vsync_in` starts nothing.
- R7: `frame_busy` stays high until `frame_done` is sampled high and falls at that edge. A `frame_done` pulse while no frame is running has no effect.
- R8: With `seq_mode`=0, the end of a frame produces exactly one cycle of `go_clear`=1, starting at the same edge where `frame_busy` falls.
- R9: With `seq_mode`=1, `go_clear` is never raised. While `go_en` and `start_in` stay high, the next trigger edge after a frame ends starts a new frame. If `start_in` is low when the frame ends, further triggers start nothing.
- R10: Dropping `go_en` during a frame does not cut that frame short, but no later frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| hard_rst_n | input | 1 | Raw hard reset pin, active low, sampled on `clk` |
| go_en | input | 1 | Enable bit from the host register |
| start_in | input | 1 | External start level |
| seq_mode | input | 1 | 1 = sequential, 0 = single frame |
| compress | input | 1 | 1 = compression (vsync trigger), 0 = expansion (dsync trigger) |
| vsync_in | input | 1 | Vertical input enable |
| dsync_in | input | 1 | Data sync from the codec side |
| frame_done | input | 1 | End-of-frame pulse from the datapath |
| frame_busy | output | 1 | High while a frame is being processed |
| go_clear | output | 1 | One-cycle request to clear the host enable bit |
| core_rst_n | output | 1 | Qualified and stretched internal reset, active low |

## Verification
The checker watches several rules on every cycle. A frame may only begin after an enabled cycle and a real rising edge on the trigger that the direction selects. Busy is held until `frame_done`. `go_clear` is always a single cycle that follows a single-frame end, and it never appears in sequential operation. The bench scenarios show the behaviour that spans many cycles or depends on the absence of an event. That covers the exact 8-sample threshold and the release stretch of the reset filter, and the fact that short glitches are ignored. It also covers the ignored edges on the unused trigger, the blocking effect of `start_in` and `go_en`, and the difference between single-frame and sequential operation.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_BUSY  = 2'd2
  } seq_state_t;

  localparam int unsigned TRIG_VSYNC = 0;
  localparam int unsigned TRIG_DSYNC = 1;
  localparam int unsigned TRIG_NUM   = 2;
endpackage

// File: rtl/fs_rst_filter.sv
module fs_rst_filter #(
  parameter int unsigned MIN_LOW  = 8,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic blk_rst
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [MIN_LOW-1:0] hist_q;
  logic [HW-1:0]      hold_q, hold_nx;
  logic               qual;
  logic               rst_nx;

  // qualified once the last MIN_LOW samples were all low
  assign qual = (hist_q == '0);

  always_comb begin
    hold_nx = hold_q;
    if (qual)
      hold_nx = HW'(HOLD_CYC);
    else if (hold_q != '0)
      hold_nx = hold_q - 1'b1;
    rst_nx = qual || (hold_q != '0);
  end

  always_ff @(posedge clk) begin
    hist_q  <= {hist_q[MIN_LOW-2:0], pin_n};
    hold_q  <= hold_nx;
    blk_rst <= rst_nx;
  end
endmodule

// File: rtl/fs_trig_detect.sv
module fs_trig_detect
  import frame_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic compress,
  input  logic vsync_in,
  input  logic dsync_in,
  output logic trig
);
  logic [TRIG_NUM-1:0] src;
  logic [TRIG_NUM-1:0] rise;

  assign src[TRIG_VSYNC] = vsync_in;
  assign src[TRIG_DSYNC] = dsync_in;

  for (genvar i = 0; i < TRIG_NUM; i++) begin : g_edge
    logic prev_q;
    // prev starts high so a level held through reset is not an edge
    always_ff @(posedge clk or posedge rst) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= src[i];
    end
    assign rise[i] = src[i] & ~prev_q;
  end

  assign trig = compress ? rise[TRIG_VSYNC] : rise[TRIG_DSYNC];
endmodule

// File: rtl/fs_ctrl_fsm.sv
module fs_ctrl_fsm
  import frame_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_en,
  input  logic start_in,
  input  logic seq_mode,
  input  logic trig,
  input  logic frame_done,
  output logic frame_busy,
  output logic go_clear
);
  seq_state_t st_q, st_nx;
  logic       st_en;
  logic       enable;
  logic       clr_nx;

  assign enable = go_en & start_in;

  always_comb begin
    st_nx  = st_q;
    clr_nx = 1'b0;
    unique case (st_q)
      SQ_IDLE:  if (enable) st_nx = SQ_ARMED;
      SQ_ARMED: begin
        if (!enable)   st_nx = SQ_IDLE;
        else if (trig) st_nx = SQ_BUSY;
      end
      SQ_BUSY: begin
        if (frame_done) begin
          st_nx  = (seq_mode && enable) ? SQ_ARMED : SQ_IDLE;
          clr_nx = ~seq_mode;
        end
      end
      default: st_nx = SQ_IDLE;
    endcase
  end

  assign st_en = (st_nx != st_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      go_clear <= 1'b0;
    end else begin
      if (st_en) st_q <= st_nx;
      go_clear <= clr_nx;
    end
  end

  assign frame_busy = (st_q == SQ_BUSY);
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int unsigned RST_MIN_LOW  = 8,
  parameter int unsigned RST_HOLD_CYC = 2
) (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic go_en,
  input  logic start_in,
  input  logic seq_mode,
  input  logic compress,
  input  logic vsync_in,
  input  logic dsync_in,
  input  logic frame_done,
  output logic frame_busy,
  output logic go_clear,
  output logic core_rst_n
);
  logic blk_rst;
  logic trig;

  fs_rst_filter #(
    .MIN_LOW (RST_MIN_LOW),
    .HOLD_CYC(RST_HOLD_CYC)
  ) u_rst (
    .clk    (clk),
    .pin_n  (hard_rst_n),
    .blk_rst(blk_rst)
  );

  fs_trig_detect u_trig (
    .clk     (clk),
    .rst     (blk_rst),
    .compress(compress),
    .vsync_in(vsync_in),
    .dsync_in(dsync_in),
    .trig    (trig)
  );

  fs_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst       (blk_rst),
    .go_en     (go_en),
    .start_in  (start_in),
    .seq_mode  (seq_mode),
    .trig      (trig),
    .frame_done(frame_done),
    .frame_busy(frame_busy),
    .go_clear  (go_clear)
  );

  assign core_rst_n = ~blk_rst;
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk (
  input logic clk,
  input logic core_rst_n,
  input logic go_en,
  input logic start_in,
  input logic seq_mode,
  input logic compress,
  input logic vsync_in,
  input logic dsync_in,
  input logic frame_done,
  input logic frame_busy,
  input logic go_clear
);
  // R4
  enable_before_start_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(frame_busy) |-> $past(go_en && start_in));

  // R5
  vsync_edge_start_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($rose(frame_busy) && $past(compress)) |-> ($past(vsync_in) && !$past(vsync_in, 2)));

  // R6
  dsync_edge_start_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($rose(frame_busy) && !$past(compress)) |-> ($past(dsync_in) && !$past(dsync_in, 2)));

  // R7
  busy_held_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_busy && !frame_done) |=> frame_busy);

  // R8
  go_clear_cause_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(go_clear) |-> $past(frame_busy && frame_done && !seq_mode));

  // R8
  go_clear_single_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    go_clear |=> !go_clear);
endmodule

bind frame_seq frame_seq_chk u_chk (
  .clk       (clk),
  .core_rst_n(core_rst_n),
  .go_en     (go_en),
  .start_in  (start_in),
  .seq_mode  (seq_mode),
  .compress  (compress),
  .vsync_in  (vsync_in),
  .dsync_in  (dsync_in),
  .frame_done(frame_done),
  .frame_busy(frame_busy),
  .go_clear  (go_clear)
);

// File: tb/frame_seq_test.sv
module frame_seq_test;
  logic clk = 1'b0;
  logic hard_rst_n, go_en, start_in, seq_mode, compress;
  logic vsync_in, dsync_in, frame_done;
  logic frame_busy, go_clear, core_rst_n;
  int   n_run  = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  frame_seq uut (
    .clk(clk), .hard_rst_n(hard_rst_n), .go_en(go_en), .start_in(start_in),
    .seq_mode(seq_mode), .compress(compress), .vsync_in(vsync_in),
    .dsync_in(dsync_in), .frame_done(frame_done), .frame_busy(frame_busy),
    .go_clear(go_clear), .core_rst_n(core_rst_n)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    go_en = 0; start_in = 0; seq_mode = 0; compress = 1;
    vsync_in = 0; dsync_in = 0; frame_done = 0;
  endtask

  task automatic end_frame();
    frame_done = 1; tick(); frame_done = 0;
  endtask

  task automatic t_reset_entry();
    idle_inputs();
    hard_rst_n = 0;
    tick(8);
    hard_rst_n = 0;
    tick();
    chk("R1 core_rst_n low after 9 low samples", core_rst_n, 1'b0);
    chk("R1 frame_busy low in reset", frame_busy, 1'b0);
    chk("R1 go_clear low in reset", go_clear, 1'b0);
    hard_rst_n = 1;
    tick();
    chk("R2 still in reset at release edge", core_rst_n, 1'b0);
    tick();
    chk("R2 still in reset +1", core_rst_n, 1'b0);
    tick();
    chk("R2 still in reset +2", core_rst_n, 1'b0);
    tick();
    chk("R2 reset released +3", core_rst_n, 1'b1);
  endtask

  task automatic t_reset_threshold();
    idle_inputs();
    hard_rst_n = 0;
    tick(8);
    chk("R1 no reset yet after exactly 8 samples", core_rst_n, 1'b1);
    tick();
    chk("R1 reset after 8th sample edge", core_rst_n, 1'b0);
    hard_rst_n = 1;
    tick(4);
    chk("R2 out of reset", core_rst_n, 1'b1);
  endtask

  task automatic t_compress_single();
    idle_inputs();
    go_en = 1; start_in = 1; compress = 1;
    tick();
    dsync_in = 1; tick(); dsync_in = 0; tick();
    chk("R5 dsync ignored in compression", frame_busy, 1'b0);
    vsync_in = 1; tick();
    chk("R5 busy after vsync rise", frame_busy, 1'b1);
    vsync_in = 0; tick(3);
    chk("R7 busy held until done", frame_busy, 1'b1);
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 busy falls on done", frame_busy, 1'b0);
    chk("R8 go_clear pulse", go_clear, 1'b1);
    go_en = 0;
    tick();
    chk("R8 go_clear one cycle", go_clear, 1'b0);
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R8 idle after single frame", frame_busy, 1'b0);
  endtask

  task automatic t_expand();
    idle_inputs();
    go_en = 1; start_in = 1; compress = 0;
    tick();
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R6 vsync ignored in expansion", frame_busy, 1'b0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 done while idle ignored (no go_clear)", go_clear, 1'b0);
    dsync_in = 1; tick();
    chk("R6 busy after dsync rise", frame_busy, 1'b1);
    dsync_in = 0;
    end_frame();
    chk("R6 frame ends", frame_busy, 1'b0);
    go_en = 0; tick();
  endtask

  task automatic t_enable_gate();
    idle_inputs();
    go_en = 1; start_in = 0;
    tick(2);
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R4 no frame with start low", frame_busy, 1'b0);
    go_en = 0; start_in = 1;
    tick(2);
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R4 no frame with go low", frame_busy, 1'b0);
  endtask

  task automatic t_sequential();
    idle_inputs();
    seq_mode = 1; go_en = 1; start_in = 1;
    tick();
    vsync_in = 1; tick(); vsync_in = 0;
    chk("R9 first frame", frame_busy, 1'b1);
    end_frame();
    chk("R9 no go_clear in sequential", go_clear, 1'b0);
    chk("R9 frame ended", frame_busy, 1'b0);
    tick();
    vsync_in = 1; tick(); vsync_in = 0;
    chk("R9 second frame auto", frame_busy, 1'b1);
    start_in = 0;
    end_frame();
    tick();
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R9 start low blocks next frame", frame_busy, 1'b0);
    start_in = 1;
    tick();
    vsync_in = 1; tick(); vsync_in = 0;
    chk("R9 frame resumes with start", frame_busy, 1'b1);
    go_en = 0; tick(2);
    chk("R10 frame continues after go drop", frame_busy, 1'b1);
    end_frame();
    tick();
    vsync_in = 1; tick(); vsync_in = 0; tick();
    chk("R10 no new frame after go drop", frame_busy, 1'b0);
  endtask

  task automatic t_glitch_and_busy_reset();
    idle_inputs();
    go_en = 1; start_in = 1;
    tick();
    vsync_in = 1; tick(); vsync_in = 0;
    hard_rst_n = 0; tick(5); hard_rst_n = 1;
    chk("R3 short glitch no reset", core_rst_n, 1'b1);
    tick(3);
    chk("R3 frame survives glitch", frame_busy, 1'b1);
    hard_rst_n = 0; tick(9);
    chk("R1 reset clears busy frame", frame_busy, 1'b0);
    hard_rst_n = 1; tick(4);
    chk("R2 out of reset, still idle", frame_busy, 1'b0);
    go_en = 0;
  endtask

  initial begin
    idle_inputs();
    hard_rst_n = 0;
    tick(10);
    hard_rst_n = 1;
    tick(4);
    chk("R2 reset state core_rst_n", core_rst_n, 1'b1);
    chk("R1 reset state frame_busy", frame_busy, 1'b0);
    chk("R1 reset state go_clear", go_clear, 1'b0);
    t_reset_entry();
    t_reset_threshold();
    t_compress_single();
    t_expand();
    t_enable_gate();
    t_sequential();
    t_glitch_and_busy_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule